// File: doc/BRIEF.md
# Upset-Tolerant Dual-Copy Storage Cell

This block is a storage element that keeps its value through single-event upsets. The same data word is held in two independent copies. Both copies load the input on every clock edge where the enable is high. While the enable is low, each copy keeps what it holds. In that hold phase a test strobe can flip any bit of either copy, which models a particle strike.

The visible value comes from a per-bit two-input C-element with a keeper. Where the two copies agree, the output bit follows them. Where they disagree, the output bit keeps its last value. A strike on one copy therefore never reaches the next stage. A mismatch flag reports that the copies differ, and the next enabled capture rewrites both copies and clears the fault.

Striking the same bit of both copies is a double fault. Both copies then agree on the wrong value, so the output follows them and is corrupted.

Top module: `upset_tolerant_cell`

## Requirements
- R1: While rst_ni is low, both copies, q_o and mismatch_o are cleared to 0.
- R2: On a clock edge with en_i high, both copies load d_i. From that edge on, q_o equals d_i and mismatch_o is 0. Upset strobes are ignored on such an edge.
- R3: On a clock edge with en_i low and no upset strobe, both copies and q_o keep their values.
- R4: On a clock edge with en_i low, bit k of copy A inverts when upset_a_i[k] is 1. Copy B works the same way with upset_b_i.
- R5: An output bit whose two copies disagree keeps the value it had before the disagreement, so a single-copy upset leaves q_o unchanged.
- R6: An output bit whose two copies agree follows them. Flipping the same bit of both copies is a double fault that changes q_o, and flipping a copy a second time restores agreement.
- R7: An enabled capture after an upset clears mismatch_o and puts the new data on q_o.
- R8: mismatch_o is 1 exactly when at least one bit differs between the two copies.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Capture enable (transparent phase) |
| d_i | input | WIDTH | Data to store |
| upset_a_i | input | WIDTH | Test strobe: bit mask to flip in copy A |
| upset_b_i | input | WIDTH | Test strobe: bit mask to flip in copy B |
| q_o | output | WIDTH | Protected stored value |
| mismatch_o | output | 1 | High while the copies differ |

## Verification
The stored word is struck in several ways. The bench hits one copy only, then the other copy only, then different bits in each copy at once. This shows that the keeper masks a fault per bit and is not frozen as a whole word. Repeating a strike on the same bit shows that the output follows the copies again once they agree. A strike on the same bit of both copies shows the double-fault corruption, which the bench counts apart from failures. Strobes applied during an enabled capture, and a rewrite after a fault, separate the capture path from the hold path.

// File: rtl/utc_pkg.sv
package utc_pkg;
  localparam int unsigned DefWidth = 8;
endpackage

// File: rtl/utc_copy.sv
module utc_copy #(
  parameter int unsigned WIDTH = utc_pkg::DefWidth
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [WIDTH-1:0] d_i,
  input  logic [WIDTH-1:0] upset_i,
  output logic [WIDTH-1:0] val_o
);
  logic [WIDTH-1:0] store_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   store_q <= '0;
    else if (en_i) store_q <= d_i;
    else           store_q <= store_q ^ upset_i;
  end

  assign val_o = store_q;

  a_r3_hold_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && upset_i == '0) |=> $stable(val_o));
  a_r4_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && upset_i != '0) |=> (val_o == ($past(val_o) ^ $past(upset_i))));
endmodule

// File: rtl/utc_merge.sv
module utc_merge #(
  parameter int unsigned WIDTH = utc_pkg::DefWidth
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] keep_q;

  for (genvar k = 0; k < WIDTH; k++) begin : g_celem
    // C-element: follow when inputs agree, else keeper value
    assign q_o[k] = (a_i[k] == b_i[k]) ? a_i[k] : keep_q[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) keep_q <= '0;
    else         keep_q <= q_o;
  end

  a_r5_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((q_o ^ $past(q_o)) & (a_i ^ b_i)) == '0);
endmodule

// File: rtl/upset_tolerant_cell.sv
module upset_tolerant_cell #(
  parameter int unsigned WIDTH = utc_pkg::DefWidth
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [WIDTH-1:0] d_i,
  input  logic [WIDTH-1:0] upset_a_i,
  input  logic [WIDTH-1:0] upset_b_i,
  output logic [WIDTH-1:0] q_o,
  output logic             mismatch_o
);
  logic [WIDTH-1:0] copy_a, copy_b;

  utc_copy #(.WIDTH(WIDTH)) u_copy_a (
    .clk_i, .rst_ni, .en_i, .d_i, .upset_i(upset_a_i), .val_o(copy_a));
  utc_copy #(.WIDTH(WIDTH)) u_copy_b (
    .clk_i, .rst_ni, .en_i, .d_i, .upset_i(upset_b_i), .val_o(copy_b));

  utc_merge #(.WIDTH(WIDTH)) u_merge (
    .clk_i, .rst_ni, .a_i(copy_a), .b_i(copy_b), .q_o);

  assign mismatch_o = |(copy_a ^ copy_b);

  a_r2_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (!mismatch_o && q_o == $past(d_i)));
  a_r8_mismatch_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && upset_a_i == '0 && upset_b_i == '0) |=> $stable(mismatch_o));
  a_r1_reset: assert property (@(posedge clk_i)
    !rst_ni |-> (q_o == '0 && !mismatch_o));
endmodule

// File: tb/upset_tolerant_cell_test.sv
module upset_tolerant_cell_test;
  localparam int unsigned W = 8;
  logic clk = 0, rst_n = 0, en = 0;
  logic [W-1:0] d = '0, ua = '0, ub = '0;
  logic [W-1:0] q;
  logic mm;
  int checks = 0, fails = 0, dbl = 0;
  bit done = 0;

  always #2 clk = ~clk;

  upset_tolerant_cell #(.WIDTH(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .d_i(d),
    .upset_a_i(ua), .upset_b_i(ub), .q_o(q), .mismatch_o(mm));

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(logic e, logic [W-1:0] dv, logic [W-1:0] a, logic [W-1:0] b);
    @(negedge clk);
    en = e; d = dv; ua = a; ub = b;
    @(posedge clk); #1;
    en = 0; ua = '0; ub = '0;
  endtask

  task automatic t_reset;
    #1;
    chk("R1 q", q, '0);
    chk("R1 mm", W'(mm), '0);
    @(negedge clk); rst_n = 1;
  endtask

  task automatic t_capture;
    cyc(1, 8'hA5, '0, '0);
    chk("R2 q", q, 8'hA5); chk("R2 mm", W'(mm), '0);
    cyc(0, 8'h00, '0, '0);
    chk("R3 hold", q, 8'hA5);
    cyc(1, 8'h3C, 8'hFF, 8'h0F);
    chk("R2 strobe ignored q", q, 8'h3C); chk("R2 strobe ignored mm", W'(mm), '0);
  endtask

  task automatic t_single;
    cyc(0, 8'hFF, 8'h01, '0);
    chk("R5 upset A q", q, 8'h3C); chk("R4 R8 mm A", W'(mm), 1);
    cyc(0, 8'h00, '0, '0);
    chk("R5 hold with fault", q, 8'h3C); chk("R8 mm held", W'(mm), 1);
    cyc(0, 8'h00, 8'h01, '0);
    chk("R6 re-agree q", q, 8'h3C); chk("R6 R8 mm clear", W'(mm), 0);
    cyc(0, 8'h00, '0, 8'h80);
    chk("R5 upset B q", q, 8'h3C); chk("R4 mm B", W'(mm), 1);
    cyc(1, 8'h5A, '0, '0);
    chk("R7 rewrite q", q, 8'h5A); chk("R7 mm", W'(mm), 0);
  endtask

  task automatic t_split;
    cyc(0, 8'h00, 8'h02, 8'h40);
    chk("R5 split q", q, 8'h5A); chk("R8 split mm", W'(mm), 1);
    cyc(0, 8'h00, '0, 8'h40);
    chk("R4 R6 one bit back", q, 8'h5A); chk("R8 still one", W'(mm), 1);
    cyc(1, 8'hC3, '0, '0);
    chk("R7 q", q, 8'hC3);
  endtask

  task automatic t_double;
    cyc(0, 8'h00, 8'h10, 8'h10);
    // both copies flipped: output corruption expected
    chk("R6 double fault q", q, 8'hD3); chk("R6 double mm", W'(mm), 0);
    if (q !== 8'hC3) dbl++;
    cyc(1, 8'h81, '0, '0);
    chk("R7 after double", q, 8'h81);
  endtask

  task automatic t_reset_again;
    cyc(0, 8'h00, 8'h08, '0);
    @(negedge clk); rst_n = 0; #1;
    chk("R1 re-reset q", q, '0); chk("R1 re-reset mm", W'(mm), 0);
    @(negedge clk); rst_n = 1;
  endtask

  initial begin
    t_reset();
    t_capture();
    t_single();
    t_split();
    t_double();
    t_reset_again();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("NOTE double_faults_corrupting_output=%0d", dbl);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule